// File: doc/BRIEF.md
# Page-Granular Logical-to-Physical Translation Table

This block holds the translation from logical page numbers to physical page numbers for a small flash store that never writes in place. Each host write is sent to a fresh physical page taken in ascending order from an active erase block. The new location is recorded, and the page that held the previous copy of that logical page is marked stale. A trim request marks a logical page's physical copy stale in the same way and leaves the logical page unmapped. A read returns the physical page number, or an unmapped indication.

One valid bit is kept per physical page and one valid-page count per erase block. A separate cleaner uses the counts. The physical space is larger than the logical space, so whole spare blocks are held in reserve. When the active block runs out of pages, the lowest-numbered erased block becomes active. When no erased block is left, writes are refused until the cleaner hands back a block whose count has reached zero.

Top module: `lpage_xlate`

## Requirements
- R1: After reset, every logical page is unmapped, every block count reads 0 and `full` is low. Block 0 is active with its page 0 next, and every other block counts as erased.
- R2: An accepted write is placed on the next unused page of the active block, in ascending page order. The physical page number is {block, page}, that is block*PAGES_PER_BLOCK+page. The response carries `rsp_ok`=1 and that number.
- R3: When every page of the active block has been used, the next write opens the lowest-numbered erased block at page 0. That block stops counting as erased.
- R4: Writing to a logical page that is already mapped decrements the count of the block that held the old copy and increments the count of the block that receives the new one. Later reads return the new location.
- R5: A trim of a mapped page answers `rsp_ok`=1 with the old physical page number, decrements that block's count and leaves the page unmapped. A trim of an unmapped page answers `rsp_ok`=0 with `rsp_ppn`=0 and changes no count.
- R6: A read (op code 0) answers `rsp_ok`=1 with the mapped physical page number, or `rsp_ok`=0 with `rsp_ppn`=0 when the page is unmapped. Op code 1 is a write, op code 2 is a trim, and op code 3 acts as a read.
- R7: `full` is high when the active block has no unused page and no erased block remains. A write in that state answers `rsp_ok`=0 and changes neither the mapping nor any count.
- R8: An erase hand-back is accepted only for an in-range block whose count is 0 and which is neither active nor already erased. Other hand-backs are ignored. An accepted block becomes available to the allocator on the next cycle, which clears `full`.
- R9: Every request gets exactly one response, with `rsp_valid` high on the cycle after the request. `rsp_valid` is low in every other cycle.
- R10: Each block count equals the number of valid pages in that block and never exceeds PAGES_PER_BLOCK. `q_cnt` returns the count of block `q_blk`, or 0 when `q_blk` is out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_op | input | 2 | 0 read, 1 write, 2 trim, 3 read |
| req_lpn | input | 4 | Logical page number |
| erase_valid | input | 1 | Cleaner hands back an erased block |
| erase_blk | input | 3 | Block being handed back |
| q_blk | input | 3 | Block whose valid count is shown on q_cnt |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_ok | output | 1 | Write accepted, or read/trim found a mapping |
| rsp_ppn | output | 5 | Physical page number {block, page} |
| full | output | 1 | No free page and no erased block |
| q_cnt | output | 3 | Valid-page count of block q_blk |

## Verification
The assertions assume that the cleaner hands back only blocks whose pages were all invalidated. The design itself enforces this by refusing any block with a nonzero count, so the stale valid bits of an accepted block are always already clear. They also assume that `req_lpn` is always in range, and the stimulus draws every logical page number from the table's own range. Erase hand-backs in the random phase name any block, including active, erased and still-populated ones, to exercise the refusal rules. A directed run drives the store to the full state and out of it again.

// File: rtl/lpx_pkg.sv
package lpx_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_TRIM  = 2'd2,
    OP_READX = 2'd3
  } lpx_op_e;
endpackage

// File: rtl/lpx_alloc.sv
module lpx_alloc #(
  parameter int NUM_BLOCKS      = 6,
  parameter int PAGES_PER_BLOCK = 4,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int PG_W  = $clog2(PAGES_PER_BLOCK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             erase_vld,
  input  logic [BLK_W-1:0] erase_blk,
  input  logic             erase_cnt_zero,
  output logic             grant,
  output logic [BLK_W-1:0] alloc_blk,
  output logic [PG_W-1:0]  alloc_pg,
  output logic             full,
  output logic             erase_accept
);
  localparam logic [PG_W:0] WP_END = (PG_W+1)'(PAGES_PER_BLOCK);

  logic [NUM_BLOCKS-1:0] erased;
  logic [BLK_W-1:0]      act_blk;
  logic [PG_W:0]         wptr;
  logic                  act_used_up;
  logic                  have_free;
  logic [BLK_W-1:0]      free_idx;

  function automatic logic [BLK_W-1:0] lowest_set(input logic [NUM_BLOCKS-1:0] v);
    logic [BLK_W-1:0] r;
    r = '0;
    for (int i = NUM_BLOCKS - 1; i >= 0; i--) if (v[i]) r = BLK_W'(i);
    return r;
  endfunction

  assign act_used_up  = (wptr == WP_END);
  assign have_free    = |erased;
  assign free_idx     = lowest_set(erased);
  assign grant        = take && (!act_used_up || have_free);
  assign alloc_blk    = act_used_up ? free_idx : act_blk;
  assign alloc_pg     = act_used_up ? '0 : wptr[PG_W-1:0];
  assign full         = act_used_up && !have_free;
  assign erase_accept = erase_vld && erase_cnt_zero && (int'(erase_blk) < NUM_BLOCKS)
                        && !erased[erase_blk] && (erase_blk != act_blk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erased  <= {{(NUM_BLOCKS-1){1'b1}}, 1'b0};
      act_blk <= '0;
      wptr    <= '0;
    end else begin
      for (int b = 0; b < NUM_BLOCKS; b++) begin
        if (erase_accept && erase_blk == BLK_W'(b)) erased[b] <= 1'b1;
        else if (grant && act_used_up && free_idx == BLK_W'(b)) erased[b] <= 1'b0;
      end
      if (grant) begin
        if (act_used_up) begin
          act_blk <= free_idx;
          wptr    <= (PG_W+1)'(1);
        end else begin
          wptr <= wptr + 1'b1;
        end
      end
    end
  end

  p_erase_clears_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full && erase_accept |=> !full);
  p_wptr_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wptr <= WP_END);
  p_new_block_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant && act_used_up |=> wptr == (PG_W+1)'(1) && act_blk == $past(free_idx));
endmodule

// File: rtl/lpx_valid_track.sv
module lpx_valid_track #(
  parameter int NUM_BLOCKS      = 6,
  parameter int PAGES_PER_BLOCK = 4,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
  localparam int PPN_W = BLK_W + PG_W,
  localparam int CNT_W = $clog2(PAGES_PER_BLOCK + 1),
  localparam int PHYS  = NUM_BLOCKS * PAGES_PER_BLOCK
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        set_vld,
  input  logic [PPN_W-1:0]            set_ppn,
  input  logic                        clr_vld,
  input  logic [PPN_W-1:0]            clr_ppn,
  output logic [NUM_BLOCKS*CNT_W-1:0] cnt_flat
);
  logic [PHYS-1:0] pv;

  function automatic logic [CNT_W-1:0] step_cnt(input logic [CNT_W-1:0] c,
                                                input logic up, input logic down);
    return c + CNT_W'(up) - CNT_W'(down);
  endfunction

  for (genvar p = 0; p < PHYS; p++) begin : g_page
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pv[p] <= 1'b0;
      else if (set_vld && set_ppn == PPN_W'(p)) pv[p] <= 1'b1;
      else if (clr_vld && clr_ppn == PPN_W'(p)) pv[p] <= 1'b0;
    end
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    logic [CNT_W-1:0] cnt;
    logic inc, dec;
    assign inc = set_vld && set_ppn[PPN_W-1:PG_W] == BLK_W'(b);
    assign dec = clr_vld && clr_ppn[PPN_W-1:PG_W] == BLK_W'(b);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= step_cnt(cnt, inc, dec);
    end
    assign cnt_flat[b*CNT_W +: CNT_W] = cnt;

    p_cnt_matches_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt) == $countones(pv[b*PAGES_PER_BLOCK +: PAGES_PER_BLOCK]));
    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt) <= PAGES_PER_BLOCK);
  end

  p_write_fresh_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_vld |-> !pv[set_ppn]);
  p_clear_was_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_vld |-> pv[clr_ppn]);
endmodule

// File: rtl/lpage_xlate.sv
module lpage_xlate #(
  parameter int LOG_PAGES       = 16,
  parameter int NUM_BLOCKS      = 6,
  parameter int PAGES_PER_BLOCK = 4,
  localparam int LPN_W = $clog2(LOG_PAGES),
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
  localparam int PPN_W = BLK_W + PG_W,
  localparam int CNT_W = $clog2(PAGES_PER_BLOCK + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [LPN_W-1:0] req_lpn,
  input  logic             erase_valid,
  input  logic [BLK_W-1:0] erase_blk,
  input  logic [BLK_W-1:0] q_blk,
  output logic             rsp_valid,
  output logic             rsp_ok,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic             full,
  output logic [CNT_W-1:0] q_cnt
);
  import lpx_pkg::*;

  logic [PPN_W-1:0]            map_ppn [LOG_PAGES];
  logic [LOG_PAGES-1:0]        map_vld;
  logic [NUM_BLOCKS*CNT_W-1:0] cnt_flat;
  logic                        is_wr, is_trim, old_vld, grant, erase_accept;
  logic [PPN_W-1:0]            old_ppn, new_ppn;
  logic [BLK_W-1:0]            alloc_blk;
  logic [PG_W-1:0]             alloc_pg;
  logic                        set_vld, clr_vld;

  function automatic logic [CNT_W-1:0] cnt_of(input logic [NUM_BLOCKS*CNT_W-1:0] f,
                                              input logic [BLK_W-1:0] blk);
    if (int'(blk) >= NUM_BLOCKS) return '0;
    return f[int'(blk)*CNT_W +: CNT_W];
  endfunction

  assign is_wr   = req_valid && lpx_op_e'(req_op) == OP_WRITE;
  assign is_trim = req_valid && lpx_op_e'(req_op) == OP_TRIM;
  assign old_vld = map_vld[req_lpn];
  assign old_ppn = map_ppn[req_lpn];
  assign new_ppn = {alloc_blk, alloc_pg};
  assign set_vld = grant;
  assign clr_vld = (grant || is_trim) && old_vld;
  assign q_cnt   = cnt_of(cnt_flat, q_blk);

  lpx_alloc #(.NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK)) alloc_i (
    .clk(clk), .rst_n(rst_n), .take(is_wr), .erase_vld(erase_valid),
    .erase_blk(erase_blk), .erase_cnt_zero(cnt_of(cnt_flat, erase_blk) == '0),
    .grant(grant), .alloc_blk(alloc_blk), .alloc_pg(alloc_pg), .full(full),
    .erase_accept(erase_accept));

  lpx_valid_track #(.NUM_BLOCKS(NUM_BLOCKS), .PAGES_PER_BLOCK(PAGES_PER_BLOCK)) track_i (
    .clk(clk), .rst_n(rst_n), .set_vld(set_vld), .set_ppn(new_ppn),
    .clr_vld(clr_vld), .clr_ppn(old_ppn), .cnt_flat(cnt_flat));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_vld   <= '0;
      for (int i = 0; i < LOG_PAGES; i++) map_ppn[i] <= '0;
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_ppn   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        if (is_wr) begin
          rsp_ok  <= grant;
          rsp_ppn <= grant ? new_ppn : '0;
        end else begin
          rsp_ok  <= old_vld;
          rsp_ppn <= old_vld ? old_ppn : '0;
        end
      end
      if (grant) begin
        map_vld[req_lpn] <= 1'b1;
        map_ppn[req_lpn] <= new_ppn;
      end else if (is_trim) begin
        map_vld[req_lpn] <= 1'b0;
      end
    end
  end

  p_resp_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_full_rejects_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr && full |=> rsp_valid && !rsp_ok);
  p_trim_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_trim && !old_vld |=> !rsp_ok && rsp_ppn == '0);
endmodule

// File: tb/lpage_xlate_tb_top.sv
module lpage_xlate_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LP = 16, NB = 6, PPB = 4;

  logic       clk = 0, rst_n = 0;
  logic       req_valid = 0, erase_valid = 0;
  logic [1:0] req_op = 0;
  logic [3:0] req_lpn = 0;
  logic [2:0] erase_blk = 0, q_blk = 0;
  logic       rsp_valid, rsp_ok, full;
  logic [4:0] rsp_ppn;
  logic [2:0] q_cnt;

  int checks = 0, errors = 0;
  bit m_vld [LP];
  int m_ppn [LP];
  int m_cnt [NB];
  bit m_free[NB];
  int m_act, m_wptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpage_xlate dut_i (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_lpn(req_lpn), .erase_valid(erase_valid), .erase_blk(erase_blk), .q_blk(q_blk),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_ppn(rsp_ppn), .full(full), .q_cnt(q_cnt));

  function automatic int lowest_free();
    for (int b = 0; b < NB; b++) if (m_free[b]) return b;
    return -1;
  endfunction

  function automatic bit model_full();
    return (m_wptr == PPB) && (lowest_free() < 0);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_counts(string tag);
    for (int b = 0; b < 7; b++) begin
      q_blk = 3'(b);
      #1;
      chk(tag, int'(q_cnt), (b < NB) ? m_cnt[b] : 0);
    end
  endtask

  task automatic do_op(int op, int lpn, string tag);
    bit eok; int eppn; int blk, pg;
    eok = 0; eppn = 0;
    if (op == 1) begin
      if (!model_full()) begin
        if (m_wptr == PPB) begin
          blk = lowest_free(); m_free[blk] = 0; m_act = blk; pg = 0; m_wptr = 1;
        end else begin
          blk = m_act; pg = m_wptr; m_wptr++;
        end
        if (m_vld[lpn]) m_cnt[m_ppn[lpn] / PPB]--;
        m_vld[lpn] = 1; m_ppn[lpn] = blk * PPB + pg; m_cnt[blk]++;
        eok = 1; eppn = m_ppn[lpn];
      end
    end else begin
      eok = m_vld[lpn]; eppn = eok ? m_ppn[lpn] : 0;
      if (op == 2 && eok) begin
        m_cnt[m_ppn[lpn] / PPB]--; m_vld[lpn] = 0;
      end
    end
    @(negedge clk);
    req_valid = 1; req_op = 2'(op); req_lpn = 4'(lpn);
    @(posedge clk); #1;
    req_valid = 0;
    chk({tag, " R9 rsp_valid"}, int'(rsp_valid), 1);
    chk({tag, " ok"}, int'(rsp_ok), int'(eok));
    chk({tag, " ppn"}, int'(rsp_ppn), eppn);
    chk({tag, " R7 full"}, int'(full), int'(model_full()));
  endtask

  task automatic do_erase(int blk, string tag);
    bit acc;
    acc = (blk < NB) && m_cnt[blk] == 0 && !m_free[blk] && m_act != blk;
    @(negedge clk);
    erase_valid = 1; erase_blk = 3'(blk);
    @(posedge clk); #1;
    erase_valid = 0;
    if (acc) m_free[blk] = 1;
    chk({tag, " R8 full after erase"}, int'(full), int'(model_full()));
    chk({tag, " R9 no rsp"}, int'(rsp_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r;
    void'($urandom(32'd4242));
    for (int i = 0; i < LP; i++) begin m_vld[i] = 0; m_ppn[i] = 0; end
    for (int b = 0; b < NB; b++) begin m_cnt[b] = 0; m_free[b] = (b != 0); end
    m_act = 0; m_wptr = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 full at reset", int'(full), 0);
    chk("R1 rsp_valid at reset", int'(rsp_valid), 0);
    @(negedge clk); rst_n = 1;
    check_counts("R1 counts at reset");
    do_op(0, 5, "R1 read unmapped");
    do_op(2, 5, "R5 trim unmapped");
    // R2: ascending pages in block 0, then R3: block 1 page 0 = ppn 4
    for (int i = 0; i < 4; i++) do_op(1, i, "R2 fill block0");
    do_op(1, 4, "R3 open next block");
    chk("R3 directed ppn", int'(rsp_ppn), 4);
    do_op(1, 0, "R4 overwrite");
    check_counts("R4 counts");
    do_op(0, 0, "R6 read new copy");
    do_op(3, 1, "R6 op3 read");
    do_op(2, 1, "R5 trim mapped");
    do_op(0, 1, "R5 read after trim");
    check_counts("R5 counts");
    // R7: drive to full
    for (int i = 0; i < 24 && !model_full(); i++) do_op(1, i % LP, "R7 fill");
    chk("R7 directed full", int'(full), 1);
    do_op(1, 7, "R7 rejected write");
    check_counts("R7 counts unchanged");
    do_op(0, 7, "R7 map unchanged");
    do_erase(m_act, "R8 active refused");
    for (int b = 0; b < NB; b++) if (m_cnt[b] != 0) begin do_erase(b, "R8 populated refused"); break; end
    do_erase(6, "R8 out of range");
    for (int b = 0; b < NB; b++) if (m_cnt[b] == 0 && m_act != b) begin do_erase(b, "R8 accept"); break; end
    do_erase(lowest_free() < 0 ? 0 : lowest_free(), "R8 already erased");
    do_op(1, 9, "R3 write after erase");
    check_counts("R10 counts directed");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      r = int'($urandom % 10);
      if (r < 5)      do_op(1, int'($urandom % LP), "R2 rand write");
      else if (r < 7) do_op(0, int'($urandom % LP), "R6 rand read");
      else if (r < 8) do_op(2, int'($urandom % LP), "R5 rand trim");
      else            do_erase(int'($urandom % NB), "R8 rand erase");
      if (n % 50 == 0) check_counts("R10 rand counts");
    end
    check_counts("R10 final counts");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule